// File: doc/BRIEF.md
# Serial Register Port with CRC-8 Protection

This block is the configuration side of a serial slave. A host frames each transfer with an active-low select, clocks a 16-bit command word in MSB first, and the block decodes it against a small register file once the select returns high. A command either writes a register or asks for one. Read data comes back on the data-out line during the host's next frame, whatever that frame carries. A no-op command (all zeros) is the usual filler for that frame.

Two independent switches add CRC-8 protection (polynomial x^8+x^2+x+1, seed 0x00, over the 16 command or response bits). With write protection on, a write frame must be 24 bits long and end with the matching check byte. If the check byte is wrong, the frame changes no register and sets a sticky error flag. With read protection on, the response is followed by its own check byte. Writing set codes to the reset field pulses a soft or a hard reset, and the output-lane field is decoded for the data path next to this block.

All serial pins are sampled by the system clock through synchronizers, so SCLK must be several system clocks per half period. There is no valid/ready handshake anywhere. The serial host paces every transfer and cannot be held off, so no back-pressure exists. The rest of the control and status pins are plain levels or one-cycle pulses.

Top module: `spi_regport`

## Requirements
- R1: A frame is read as bit 15 = write flag (1 write, 0 read), bits 14:12 = address, bits 11:0 = data. Bits are captured on SCLK falling edges, MSB first. An accepted write takes effect after the select rises. Register map:
  - address 1 mode: [1:0] lane field, [2] write-CRC enable, [3] read-CRC enable, reset 0.
  - address 4 scratch: 12 bits, reset 0x5A0.
- R2: An accepted read makes the next frame shift out {1'b0, address[2:0], data[11:0]} MSB first, the first bit valid from the select fall and each later bit after an SCLK fall. Any other frame leaves zeros for the next one. Addresses 0, 2, 5, 6 and 7 read as data 0.
- R3: A frame whose bit count at select rise is not a valid length is ignored. Valid lengths are 16, or 24 for a write with write-CRC on (exactly 24 then), or 24 for a read with read-CRC on.
- R4: With write-CRC on, a 24-bit write whose last 8 bits equal the CRC-8 of its first 16 bits is applied.
- R5: With write-CRC on, a 24-bit write with a wrong check byte changes no register and sets the CRC error flag (status address 3, bit 0). Writing 1 to that bit clears it.
- R6: When read-CRC is on at the read, the response frame shifts out 8 more bits after the 16 response bits: the CRC-8 of those 16 bits.
- R7: Writing 0x3C to the reset field (address 2, bits 7:0) pulses soft_rst for one cycle and clears the alert flag, leaving the other registers unchanged.
- R8: Writing 0xFF to the reset field pulses hard_rst for one cycle and returns mode, scratch, CRC error and alert to their reset values.
- R9: four_lane is 1 exactly when the lane field is 0b10. two_lane is 1 exactly when it is 0b00.
- R10: A one-cycle alert_in pulse sets alert_flag, which stays set. It reads as status bit 1.
- R11: After reset, all outputs are 0 except two_lane, which is 1, and scratch reads 0x5A0.
- R12: Any other reset-field code gives no reset pulse. The reset field always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial response output |
| alert_in | input | 1 | Pulse that sets the alert flag |
| lane_mode | output | 2 | Raw lane field |
| four_lane | output | 1 | Lane field decodes to four lanes |
| two_lane | output | 1 | Lane field decodes to two lanes |
| wr_crc_en | output | 1 | Write CRC required |
| rd_crc_en | output | 1 | Read CRC appended |
| crc_err | output | 1 | Sticky write CRC error |
| alert_flag | output | 1 | Sticky alert status |
| soft_rst | output | 1 | One-cycle soft reset request |
| hard_rst | output | 1 | One-cycle hard reset request |

## Verification
The mode register is swept through all sixteen values. This toggles both CRC enables in the middle of the sweep, so frame length, check-byte generation and lane decode are each tested under every other setting. A write is corrupted at every one of the eight check-byte positions, and frames one bit short or long are sent, to tell a discarded frame from an applied one. Every address is read back, and the reset field is written with both reset codes and with a neutral code, so soft and hard resets can be told apart by what they keep.

// File: rtl/spi_regport_pkg.sv
`timescale 1ns/1ps
package spi_regport_pkg;
  localparam int CMD_W  = 16;
  localparam int CRC_W  = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = CMD_W - ADDR_W - 1;
  localparam int MODE_W = 4;
  localparam int FRAME_MAX = CMD_W + CRC_W;

  localparam logic [CRC_W-1:0] CRC_POLY  = 8'h07;
  localparam logic [7:0]       CODE_SOFT = 8'h3C;
  localparam logic [7:0]       CODE_HARD = 8'hFF;

  typedef enum logic [ADDR_W-1:0] {
    A_NOP  = 3'd0,
    A_MODE = 3'd1,
    A_RST  = 3'd2,
    A_STAT = 3'd3,
    A_SCR  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  // Serial CRC-8, seed zero, MSB first
  function automatic logic [CRC_W-1:0] crc8(input logic [CMD_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = CMD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/spi_regport_sync.sv
`timescale 1ns/1ps
module spi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b001;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic [1:0]      last;

  assign raw = {sdi, sclk, cs_n};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IDLE[1:0];
    else        last <= synced[1:0];
  end

  assign cs_fall   =  last[0] & ~synced[0];
  assign cs_rise   = ~last[0] &  synced[0];
  assign sclk_fall =  last[1] & ~synced[1] & ~synced[0];
  assign sdi_s     =  synced[2];
endmodule

// File: rtl/spi_regport_rx.sv
`timescale 1ns/1ps
module spi_regport_rx
  import spi_regport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic sclk_fall,
  input  logic sdi_s,
  input  logic wcrc_en,
  input  logic rcrc_en,
  output logic frame_end,
  output logic cmd_ok,
  output logic crc_bad,
  output cmd_t cmd
);
  localparam int CNT_W = $clog2(FRAME_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;
  localparam logic [CNT_W-1:0] LEN_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(FRAME_MAX);

  logic [FRAME_MAX-1:0] sh;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (sclk_fall) begin
      sh <= {sh[FRAME_MAX-2:0], sdi_s};
      if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end
  end

  logic             len_short, len_long, crc_match;
  logic             ok_c, bad_c;
  cmd_t             cmd_c;
  logic [CRC_W-1:0] crc_rx;

  assign len_short = (cnt == LEN_CMD);
  assign len_long  = (cnt == LEN_FULL);
  assign cmd_c     = len_long ? cmd_t'(sh[FRAME_MAX-1:CRC_W]) : cmd_t'(sh[CMD_W-1:0]);
  assign crc_rx    = sh[CRC_W-1:0];
  assign crc_match = (crc8(sh[FRAME_MAX-1:CRC_W]) == crc_rx);

  always_comb begin
    ok_c  = 1'b0;
    bad_c = 1'b0;
    if (cmd_c.wr) begin
      if (wcrc_en) begin
        ok_c  = len_long & crc_match;
        bad_c = len_long & ~crc_match;
      end else begin
        ok_c  = len_short;
      end
    end else begin
      ok_c = len_short | (len_long & rcrc_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_end <= 1'b0;
      cmd_ok    <= 1'b0;
      crc_bad   <= 1'b0;
      cmd       <= '0;
    end else begin
      frame_end <= cs_rise;
      cmd_ok    <= cs_rise & ok_c;
      crc_bad   <= cs_rise & bad_c;
      if (cs_rise) cmd <= cmd_c;
    end
  end

  a_r3_len_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> (cnt == LEN_CMD || cnt == LEN_FULL));
  a_r5_bad_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |-> (cnt == LEN_FULL && !cmd_ok));
endmodule

// File: rtl/spi_regport_regs.sv
`timescale 1ns/1ps
module spi_regport_regs
  import spi_regport_pkg::*;
#(
  parameter logic [DATA_W-1:0] SCRATCH_RST = 12'h5A0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_end,
  input  logic                 cmd_ok,
  input  logic                 crc_bad,
  input  cmd_t                 cmd,
  input  logic                 alert_in,
  output logic [MODE_W-1:0]    mode,
  output logic                 crc_err,
  output logic                 alert_flag,
  output logic                 soft_rst,
  output logic                 hard_rst,
  output logic [FRAME_MAX-1:0] resp
);
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] scr_q;
  logic              crc_q, alert_q, soft_q, hard_q;
  logic [FRAME_MAX-1:0] resp_q;

  logic wr_en, rd_en, is_soft, is_hard;
  assign wr_en   = cmd_ok & cmd.wr;
  assign rd_en   = cmd_ok & ~cmd.wr;
  assign is_soft = wr_en && (cmd.addr == A_RST) && (cmd.data[7:0] == CODE_SOFT);
  assign is_hard = wr_en && (cmd.addr == A_RST) && (cmd.data[7:0] == CODE_HARD);

  logic [DATA_W-1:0] rdata;
  logic [CMD_W-1:0]  rword;
  always_comb begin
    unique case (cmd.addr)
      A_MODE:  rdata = DATA_W'(mode_q);
      A_STAT:  rdata = DATA_W'({alert_q, crc_q});
      A_SCR:   rdata = scr_q;
      default: rdata = '0;
    endcase
  end
  assign rword = {1'b0, cmd.addr, rdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      scr_q   <= SCRATCH_RST;
      crc_q   <= 1'b0;
      alert_q <= 1'b0;
      soft_q  <= 1'b0;
      hard_q  <= 1'b0;
      resp_q  <= '0;
    end else begin
      soft_q <= is_soft;
      hard_q <= is_hard;
      if (frame_end)
        resp_q <= rd_en ? {rword, (mode_q[3] ? crc8(rword) : 8'h00)} : '0;
      if (is_hard) begin
        mode_q  <= '0;
        scr_q   <= SCRATCH_RST;
        crc_q   <= 1'b0;
        alert_q <= 1'b0;
      end else begin
        if (wr_en && cmd.addr == A_MODE) mode_q <= cmd.data[MODE_W-1:0];
        if (wr_en && cmd.addr == A_SCR)  scr_q  <= cmd.data;
        if (crc_bad)                                       crc_q <= 1'b1;
        else if (wr_en && cmd.addr == A_STAT && cmd.data[0]) crc_q <= 1'b0;
        if (is_soft)       alert_q <= 1'b0;
        else if (alert_in) alert_q <= 1'b1;
      end
    end
  end

  assign mode       = mode_q;
  assign crc_err    = crc_q;
  assign alert_flag = alert_q;
  assign soft_rst   = soft_q;
  assign hard_rst   = hard_q;
  assign resp       = resp_q;

  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode_q) && $stable(scr_q)));
  a_r5_discard_bad_crc: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |=> ($stable(mode_q) && $stable(scr_q) && crc_q));
  a_r7_soft_clears_alert: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !alert_flag);
  a_r8_hard_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |-> (mode_q == '0 && scr_q == SCRATCH_RST && !crc_q && !alert_q));
endmodule

// File: rtl/spi_regport_tx.sv
`timescale 1ns/1ps
module spi_regport_tx
  import spi_regport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_fall,
  input  logic                 sclk_fall,
  input  logic [FRAME_MAX-1:0] word,
  output logic                 sdo
);
  logic [FRAME_MAX-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sh <= '0;
    else if (cs_fall)   sh <= word;
    else if (sclk_fall) sh <= {sh[FRAME_MAX-2:0], 1'b0};
  end

  assign sdo = sh[FRAME_MAX-1];

  a_r2_sdo_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_fall && !sclk_fall) |=> $stable(sdo));
endmodule

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] SCRATCH_RST = 12'h5A0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  input  logic       alert_in,
  output logic [1:0] lane_mode,
  output logic       four_lane,
  output logic       two_lane,
  output logic       wr_crc_en,
  output logic       rd_crc_en,
  output logic       crc_err,
  output logic       alert_flag,
  output logic       soft_rst,
  output logic       hard_rst
);
  logic cs_fall, cs_rise, sclk_fall, sdi_s;
  logic frame_end, cmd_ok, crc_bad;
  cmd_t cmd;
  logic [MODE_W-1:0]    mode;
  logic [FRAME_MAX-1:0] resp;

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s));

  spi_regport_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .wcrc_en(mode[2]), .rcrc_en(mode[3]),
    .frame_end(frame_end), .cmd_ok(cmd_ok), .crc_bad(crc_bad), .cmd(cmd));

  spi_regport_regs #(.SCRATCH_RST(SCRATCH_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cmd_ok(cmd_ok),
    .crc_bad(crc_bad), .cmd(cmd), .alert_in(alert_in), .mode(mode),
    .crc_err(crc_err), .alert_flag(alert_flag), .soft_rst(soft_rst),
    .hard_rst(hard_rst), .resp(resp));

  spi_regport_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .word(resp), .sdo(sdo));

  assign lane_mode = mode[1:0];
  assign four_lane = (mode[1:0] == 2'b10);
  assign two_lane  = (mode[1:0] == 2'b00);
  assign wr_crc_en = mode[2];
  assign rd_crc_en = mode[3];

  a_r12_one_reset_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({soft_rst, hard_rst}) <= 1);
  a_r5_err_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(crc_bad));
endmodule

// File: tb/spi_regport_tb.sv
`timescale 1ns/1ps
module spi_regport_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, alert_in = 1'b0;
  logic sdo, four_lane, two_lane, wr_crc_en, rd_crc_en, crc_err, alert_flag, soft_rst, hard_rst;
  logic [1:0] lane_mode;

  int total = 0, bad = 0, n_soft = 0, n_hard = 0;
  bit done = 1'b0;

  logic [3:0]  m_mode = 4'h0;
  logic [11:0] m_scr = 12'h5A0;
  logic        m_crc = 1'b0, m_alert = 1'b0;

  always #10 clk = ~clk;

  spi_regport u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .alert_in(alert_in), .lane_mode(lane_mode), .four_lane(four_lane),
    .two_lane(two_lane), .wr_crc_en(wr_crc_en), .rd_crc_en(rd_crc_en),
    .crc_err(crc_err), .alert_flag(alert_flag), .soft_rst(soft_rst),
    .hard_rst(hard_rst));

  always @(posedge clk) begin
    if (soft_rst) n_soft++;
    if (hard_rst) n_hard++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // polynomial long division by 0x107
  function automatic logic [7:0] ref_crc(input logic [15:0] d);
    logic [23:0] r;
    r = {d, 8'h00};
    for (int i = 23; i >= 8; i--)
      if (r[i]) r = r ^ (24'h107 << (i - 8));
    return r[7:0];
  endfunction

  function automatic logic [15:0] exp_word(input logic [2:0] a);
    logic [11:0] v;
    case (a)
      3'd1:    v = {8'h00, m_mode};
      3'd3:    v = {10'h000, m_alert, m_crc};
      3'd4:    v = m_scr;
      default: v = 12'h000;
    endcase
    return {1'b0, a, v};
  endfunction

  task automatic frame(input logic [23:0] w, input int nb, output logic [23:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    tick(6);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi  = w[i];
      sclk = 1'b1;
      tick(4);
      rx   = {rx[22:0], sdo};
      sclk = 1'b0;
      tick(4);
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    tick(8);
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    logic [15:0] c;
    logic [23:0] rx;
    c = {1'b1, a, d};
    if (m_mode[2]) frame({c, ref_crc(c)}, 24, rx);
    else           frame({8'h00, c}, 16, rx);
    case (a)
      3'd1: m_mode = d[3:0];
      3'd2: begin
        if (d[7:0] == 8'h3C) m_alert = 1'b0;
        else if (d[7:0] == 8'hFF) begin
          m_mode = 4'h0; m_scr = 12'h5A0; m_crc = 1'b0; m_alert = 1'b0;
        end
      end
      3'd3: if (d[0]) m_crc = 1'b0;
      3'd4: m_scr = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    logic [15:0] c, e;
    logic [23:0] rx;
    int nb;
    nb = m_mode[3] ? 24 : 16;
    c  = {1'b0, a, 12'h000};
    e  = exp_word(a);
    frame(nb == 24 ? {c, 8'h00} : {8'h00, c}, nb, rx);
    frame(24'h0, nb, rx);
    if (nb == 24) begin
      check({tag, " R2 read word"}, {16'h0, rx[23:8]}, {16'h0, e});
      check({tag, " R6 read crc"}, {24'h0, rx[7:0]}, {24'h0, ref_crc(e)});
    end else begin
      check({tag, " R2 read word"}, {16'h0, rx[15:0]}, {16'h0, e});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx;
    logic [15:0] c;
    int s0, h0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R11 reset state
    check("R11 sdo", {31'h0, sdo}, 0);
    check("R11 outputs", {24'h0, lane_mode, four_lane, two_lane, wr_crc_en, rd_crc_en, crc_err, alert_flag},
          {24'h0, 8'b00_0_1_0_0_0_0});
    check("R11 pulses", {30'h0, soft_rst, hard_rst}, 0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R11 R2 default");

    // R1 R9 R4 R6 exhaustive mode sweep
    for (int v = 0; v < 16; v++) begin
      wr(3'd1, 12'(v));
      check("R9 four_lane", {31'h0, four_lane}, {31'h0, (v[1:0] == 2'b10)});
      check("R9 two_lane", {31'h0, two_lane}, {31'h0, (v[1:0] == 2'b00)});
      check("R1 mode outputs", {28'h0, rd_crc_en, wr_crc_en, lane_mode}, 32'(v));
      rd_chk(3'd1, "R1 mode");
    end

    // R4 protected scratch writes (both CRC enables on now)
    for (int k = 0; k < 8; k++) begin
      wr(3'd4, 12'((k * 12'h13B) ^ 12'hA5A));
      rd_chk(3'd4, "R4 scratch");
    end

    // R5 each single-bit check byte corruption
    for (int b = 0; b < 8; b++) begin
      c = {1'b1, 3'd4, 12'h0F0};
      frame({c, ref_crc(c) ^ (8'h01 << b)}, 24, rx);
      m_crc = 1'b1;
      check("R5 crc_err set", {31'h0, crc_err}, 1);
      rd_chk(3'd4, "R5 scratch kept");
      rd_chk(3'd3, "R5 status");
      wr(3'd3, 12'h001);
      check("R5 crc_err cleared", {31'h0, crc_err}, 0);
    end

    // R3 short write while write CRC required
    c = {1'b1, 3'd4, 12'h111};
    frame({8'h00, c}, 16, rx);
    check("R3 16-bit write with crc on", {31'h0, crc_err}, 0);
    rd_chk(3'd4, "R3 scratch kept");

    // R3 wrong counts with CRC off
    wr(3'd1, 12'h000);
    for (int nb = 15; nb <= 23; nb += 2) begin
      c = {1'b1, 3'd4, 12'h777};
      frame({c, 8'h00} >> (24 - nb), nb, rx);
      rd_chk(3'd4, "R3 odd length ignored");
    end
    frame({8'h00, 1'b1, 3'd4, 12'h777}, 24, rx);
    rd_chk(3'd4, "R3 24-bit write with crc off");

    // R10 alert
    @(negedge clk); alert_in = 1'b1;
    @(negedge clk); alert_in = 1'b0;
    tick(2);
    m_alert = 1'b1;
    check("R10 alert_flag", {31'h0, alert_flag}, 1);
    rd_chk(3'd3, "R10 status");

    // R12 neutral code
    wr(3'd1, 12'h002);
    s0 = n_soft; h0 = n_hard;
    wr(3'd2, 12'h05A);
    check("R12 no pulse", n_soft + n_hard, s0 + h0);
    rd_chk(3'd2, "R12 reset field");
    check("R12 alert kept", {31'h0, alert_flag}, 1);

    // R7 soft reset
    wr(3'd4, 12'h3C3);
    wr(3'd2, 12'h03C);
    check("R7 soft pulse", n_soft, s0 + 1);
    check("R7 no hard", n_hard, h0);
    check("R7 alert cleared", {31'h0, alert_flag}, 0);
    check("R7 mode kept", {31'h0, four_lane}, 1);
    rd_chk(3'd4, "R7 scratch kept");

    // R8 hard reset with everything non-default
    wr(3'd1, 12'h00E);
    c = {1'b1, 3'd4, 12'h001};
    frame({c, ref_crc(c) ^ 8'h80}, 24, rx);
    m_crc = 1'b1;
    @(negedge clk); alert_in = 1'b1;
    @(negedge clk); alert_in = 1'b0;
    m_alert = 1'b1;
    tick(2);
    wr(3'd2, 12'h0FF);
    check("R8 hard pulse", n_hard, h0 + 1);
    check("R8 outputs", {24'h0, lane_mode, four_lane, two_lane, wr_crc_en, rd_crc_en, crc_err, alert_flag},
          {24'h0, 8'b00_0_1_0_0_0_0});
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R8 defaults");

    // R1 scratch data sweep, CRC off
    for (int k = 0; k < 24; k++) begin
      wr(3'd4, 12'((k * 12'h1A7 + 12'h3) & 12'hFFF));
      rd_chk(3'd4, "R1 scratch data");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule